// File: doc/BRIEF.md
# Per-Processor Interrupt Claim and Retire Interface

This block sits between an interrupt distributor and one processor. The distributor is modelled as a vector of one-cycle pending pulses, plus a fixed priority value for each interrupt. The block latches those pulses, picks the most urgent interrupt that is pending, not already in service, and more urgent than a programmable threshold. It drives one request line to the processor.

Software claims an interrupt with an acknowledge strobe. The winner moves from pending to in-service in the same clock edge, and its identifier is returned on the next cycle. When nothing qualifies, the reserved identifier 1023 comes back instead, which software uses to end its service loop. Software retires an interrupt by writing its identifier to the completion port. For identifiers below 16, which are raised by other processors, the completion value must also carry the source processor field that the claim returned.

Top module: `icpu_ack_if`

## Requirements
- R1: After reset the request line is low, signalling is disabled, the threshold is 0, and the acknowledge data reads 1023.
- R2: While the enable bit (bit 0 of the control write) is 0, the request line stays low. An acknowledge strobe then returns 1023 and changes no pending or in-service state.
- R3: An interrupt qualifies only if its priority value is numerically below the threshold. A value equal to the threshold does not qualify.
- R4: Among qualifying interrupts, the lowest priority value wins. On equal values, the lowest identifier wins.
- R5: Acknowledge data appears the cycle after the strobe and holds until the next strobe. Bits [9:0] carry the identifier. Bits [9+SRC_W:10] carry the source processor for identifiers below 16, and are zero for all other identifiers.
- R6: An acknowledge that finds a winner clears that interrupt's pending state and marks it in service. An in-service interrupt is never presented or claimed again until it is retired.
- R7: An acknowledge with no qualifying interrupt returns 1023 and changes no state.
- R8: A completion write whose bits [9:0] name an in-service identifier of 16 or above ends its service. The interrupt is presented again only if it becomes pending again.
- R9: A completion write for an identifier below 16 ends its service only if bits [9+SRC_W:10] equal the source returned by the claim. Any other value is ignored.
- R10: The request line is registered. It rises or falls one cycle after the pending, in-service, threshold or enable state that it reflects.
- R11: A pending pulse that arrives while the same interrupt is in service is held. That interrupt is presented again after it is retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_set_i | input | NUM_IRQ | One-cycle pulses that mark interrupts pending |
| pend_src_i | input | SRC_W | Source processor captured with pulses on identifiers below 16 |
| prio_i | input | NUM_IRQ*PRIO_W | Priority value per interrupt, identifier n at bits [n*PRIO_W +: PRIO_W] |
| ctrl_we_i | input | 1 | Write strobe for the enable bit |
| ctrl_en_i | input | 1 | Enable value written by ctrl_we_i |
| pmask_we_i | input | 1 | Write strobe for the priority threshold |
| pmask_i | input | PRIO_W | Threshold value written by pmask_we_i |
| ack_rd_i | input | 1 | Acknowledge (claim) strobe |
| ack_data_o | output | 10+SRC_W | Claimed identifier and source, or 1023 |
| eoi_we_i | input | 1 | Completion write strobe |
| eoi_data_i | input | 10+SRC_W | Completion value: identifier and source |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The arbitration is exercised with three interrupts of mixed priority, two of which tie. The claim order separates the lowest-value rule from the lowest-identifier tie break. Threshold tests use a priority exactly equal to the threshold, then one step below it, which catches an off-by-one comparison. A re-raised interrupt that is still in service, and a completion for a processor-raised interrupt that carries the wrong source, both show whether in-service blocking and the source match are real. Disabled-interface claims followed by enabling show that the pending state was kept intact.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
   localparam int unsigned ID_W    = 10;
   localparam int unsigned NUM_SGI = 16;
   localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
endpackage

// File: rtl/icpu_pick.sv
module icpu_pick
   import icpu_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned PRIO_W  = 8,
   parameter bit          TREE    = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        pend_i,
   input  logic [NUM_IRQ-1:0]        act_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]         pmask_i,
   output logic                      win_valid_o,
   output logic [ID_W-1:0]           win_id_o,
   output logic [PRIO_W-1:0]         win_prio_o
);
   localparam int unsigned LEAVES = 1 << $clog2(NUM_IRQ);

   logic [NUM_IRQ-1:0] elig;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_elig
      assign elig[i] = pend_i[i] & ~act_i[i] & (prio_i[i*PRIO_W +: PRIO_W] < pmask_i);
   end

   if (TREE) begin : g_tree
      logic              nv  [2*LEAVES];
      logic [PRIO_W-1:0] np  [2*LEAVES];
      logic [ID_W-1:0]   nid [2*LEAVES];

      assign nv[0]  = 1'b0;
      assign np[0]  = '0;
      assign nid[0] = '0;

      for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
         if (j < NUM_IRQ) begin : g_real
            assign nv[LEAVES+j]  = elig[j];
            assign np[LEAVES+j]  = prio_i[j*PRIO_W +: PRIO_W];
            assign nid[LEAVES+j] = ID_W'(j);
         end else begin : g_pad
            assign nv[LEAVES+j]  = 1'b0;
            assign np[LEAVES+j]  = '1;
            assign nid[LEAVES+j] = '0;
         end
      end

      for (genvar k = 1; k < LEAVES; k++) begin : g_node
         logic take_right;
         // left child holds lower IDs, so it keeps ties
         assign take_right = nv[2*k+1] && (!nv[2*k] || (np[2*k+1] < np[2*k]));
         assign nv[k]  = nv[2*k] | nv[2*k+1];
         assign np[k]  = take_right ? np[2*k+1]  : np[2*k];
         assign nid[k] = take_right ? nid[2*k+1] : nid[2*k];
      end

      assign win_valid_o = nv[1];
      assign win_prio_o  = np[1];
      assign win_id_o    = nid[1];
   end else begin : g_scan
      always_comb begin
         win_valid_o = 1'b0;
         win_prio_o  = '1;
         win_id_o    = '0;
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!win_valid_o || (prio_i[i*PRIO_W +: PRIO_W] < win_prio_o))) begin
               win_valid_o = 1'b1;
               win_prio_o  = prio_i[i*PRIO_W +: PRIO_W];
               win_id_o    = ID_W'(i);
            end
         end
      end
   end

   // R3: a presented winner always beats the threshold
   a_r3_beats_mask: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> (win_prio_o < pmask_i));

   // R6: a winner is never an interrupt already in service
   a_r6_not_active: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> ((act_i & (NUM_IRQ'(1) << win_id_o)) == '0));
endmodule

// File: rtl/icpu_track.sv
module icpu_track
   import icpu_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned SRC_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] set_i,
   input  logic [SRC_W-1:0]   set_src_i,
   input  logic               take_i,
   input  logic [ID_W-1:0]    take_id_i,
   input  logic               eoi_i,
   input  logic [ID_W-1:0]    eoi_id_i,
   input  logic [SRC_W-1:0]   eoi_src_i,
   input  logic [ID_W-1:0]    win_id_i,
   output logic [NUM_IRQ-1:0] pend_o,
   output logic [NUM_IRQ-1:0] act_o,
   output logic [SRC_W-1:0]   win_src_o
);
   logic [SRC_W-1:0] sgi_psrc [NUM_SGI];

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      logic p_q, a_q, hit_take, hit_eoi, src_ok;

      assign hit_take = take_i && (take_id_i == ID_W'(i));

      if (i < NUM_SGI) begin : g_sgi
         logic [SRC_W-1:0] psrc_q, asrc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               psrc_q <= '0;
               asrc_q <= '0;
            end else begin
               if (set_i[i]) psrc_q <= set_src_i;
               if (hit_take) asrc_q <= psrc_q;
            end
         end
         assign src_ok      = (eoi_src_i == asrc_q);
         assign sgi_psrc[i] = psrc_q;
      end else begin : g_dev
         assign src_ok = 1'b1;
      end

      assign hit_eoi = eoi_i && (eoi_id_i == ID_W'(i)) && src_ok;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= 1'b0;
            a_q <= 1'b0;
         end else begin
            p_q <= (p_q & ~hit_take) | set_i[i];
            a_q <= (a_q & ~hit_eoi) | hit_take;
         end
      end

      assign pend_o[i] = p_q;
      assign act_o[i]  = a_q;
   end

   for (genvar s = NUM_IRQ; s < NUM_SGI; s++) begin : g_sgi_fill
      assign sgi_psrc[s] = '0;
   end

   always_comb begin
      win_src_o = '0;
      for (int s = 0; s < NUM_SGI; s++) begin
         if (win_id_i == ID_W'(s)) win_src_o = sgi_psrc[s];
      end
   end

   // R6: one claim marks at most one interrupt in service per cycle
   a_r6_single_take: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(act_o & ~$past(act_o)) <= 1);

   // R11: a pending pulse is always latched
   a_r11_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

   // R8: without a claim, a completion never adds in-service interrupts
   a_r8_eoi_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_i && !take_i) |=> ($countones(act_o) <= $countones($past(act_o))));
endmodule

// File: rtl/icpu_ack_if.sv
module icpu_ack_if
   import icpu_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned PRIO_W  = 8,
   parameter int unsigned SRC_W   = 3,
   parameter bit          TREE    = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        pend_set_i,
   input  logic [SRC_W-1:0]          pend_src_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
   input  logic                      ctrl_we_i,
   input  logic                      ctrl_en_i,
   input  logic                      pmask_we_i,
   input  logic [PRIO_W-1:0]         pmask_i,
   input  logic                      ack_rd_i,
   output logic [ID_W+SRC_W-1:0]     ack_data_o,
   input  logic                      eoi_we_i,
   input  logic [ID_W+SRC_W-1:0]     eoi_data_i,
   output logic                      irq_o
);
   localparam int unsigned ACK_W = ID_W + SRC_W;

   if (NUM_IRQ <= NUM_SGI || NUM_IRQ > 1020) begin : g_bad_num
      $error("icpu_ack_if: NUM_IRQ must lie in 17..1020");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("icpu_ack_if: PRIO_W must lie in 1..8");
   end
   if (SRC_W < 1 || SRC_W > 4) begin : g_bad_src
      $error("icpu_ack_if: SRC_W must lie in 1..4");
   end

   logic                en_q, irq_q;
   logic [PRIO_W-1:0]   pmask_q;
   logic [ACK_W-1:0]    ack_q;
   logic [NUM_IRQ-1:0]  pend_w, act_w;
   logic                win_valid;
   logic [ID_W-1:0]     win_id;
   logic [PRIO_W-1:0]   win_prio;
   logic [SRC_W-1:0]    win_src;
   logic                take;
   logic [ACK_W-1:0]    take_word;

   icpu_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .TREE(TREE)) u_pick (
      .clk         (clk),
      .rst_n       (rst_n),
      .pend_i      (pend_w),
      .act_i       (act_w),
      .prio_i      (prio_i),
      .pmask_i     (pmask_q),
      .win_valid_o (win_valid),
      .win_id_o    (win_id),
      .win_prio_o  (win_prio)
   );

   icpu_track #(.NUM_IRQ(NUM_IRQ), .SRC_W(SRC_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (pend_set_i),
      .set_src_i (pend_src_i),
      .take_i    (take),
      .take_id_i (win_id),
      .eoi_i     (eoi_we_i),
      .eoi_id_i  (eoi_data_i[ID_W-1:0]),
      .eoi_src_i (eoi_data_i[ACK_W-1:ID_W]),
      .win_id_i  (win_id),
      .pend_o    (pend_w),
      .act_o     (act_w),
      .win_src_o (win_src)
   );

   assign take      = ack_rd_i && en_q && win_valid;
   assign take_word = (win_id < ID_W'(NUM_SGI)) ? {win_src, win_id} : {{SRC_W{1'b0}}, win_id};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         pmask_q <= '0;
         ack_q   <= ACK_W'(SPURIOUS_ID);
         irq_q   <= 1'b0;
      end else begin
         if (ctrl_we_i)  en_q    <= ctrl_en_i;
         if (pmask_we_i) pmask_q <= pmask_i;
         if (ack_rd_i)   ack_q   <= take ? take_word : ACK_W'(SPURIOUS_ID);
         irq_q <= en_q && win_valid;
      end
   end

   assign ack_data_o = ack_q;
   assign irq_o      = irq_q;

   // R2: request stays low while signalling is disabled
   a_r2_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !irq_o);

   // R7: claim with nothing to give returns the reserved ID
   a_r7_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd_i && !(en_q && win_valid)) |=> (ack_data_o == ACK_W'(SPURIOUS_ID)));

   // R7: a failed claim leaves in-service state untouched
   a_r7_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd_i && !(en_q && win_valid) && !eoi_we_i) |=> $stable(act_w));

   // R5: source field only for processor-raised identifiers
   a_r5_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_data_o[ID_W-1:0] >= ID_W'(NUM_SGI)) |-> (ack_data_o[ACK_W-1:ID_W] == '0));

   // R5: acknowledge data holds between strobes
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_rd_i |=> $stable(ack_data_o));

   // R10: request follows eligibility one cycle later
   a_r10_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && win_valid) |=> irq_o);
endmodule

// File: tb/test_icpu_ack_if.sv
module test_icpu_ack_if;
   localparam int N  = 64;
   localparam int PW = 8;
   localparam int SW = 3;
   localparam int AW = 10 + SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pend_set = '0;
   logic [SW-1:0] pend_src = '0;
   logic [N*PW-1:0] prio = '1;
   logic          ctrl_we = 1'b0, ctrl_en = 1'b0;
   logic          pmask_we = 1'b0;
   logic [PW-1:0] pmask = '0;
   logic          ack_rd = 1'b0;
   logic [AW-1:0] ack_data;
   logic          eoi_we = 1'b0;
   logic [AW-1:0] eoi_data = '0;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   icpu_ack_if #(.NUM_IRQ(N), .PRIO_W(PW), .SRC_W(SW)) i_icpu_ack_if (
      .clk(clk), .rst_n(rst_n), .pend_set_i(pend_set), .pend_src_i(pend_src),
      .prio_i(prio), .ctrl_we_i(ctrl_we), .ctrl_en_i(ctrl_en),
      .pmask_we_i(pmask_we), .pmask_i(pmask), .ack_rd_i(ack_rd),
      .ack_data_o(ack_data), .eoi_we_i(eoi_we), .eoi_data_i(eoi_data), .irq_o(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int id, input int src);
      pend_set = N'(1) << id;
      pend_src = SW'(src);
      @(negedge clk);
      pend_set = '0;
   endtask

   task automatic claim(output int val);
      ack_rd = 1'b1;
      @(negedge clk);
      ack_rd = 1'b0;
      val = int'(ack_data);
   endtask

   task automatic retire(input int val);
      eoi_we   = 1'b1;
      eoi_data = AW'(val);
      @(negedge clk);
      eoi_we = 1'b0;
   endtask

   task automatic set_ctrl(input bit en, input int m);
      ctrl_we = 1'b1; ctrl_en = en;
      pmask_we = 1'b1; pmask = PW'(m);
      @(negedge clk);
      ctrl_we = 1'b0; pmask_we = 1'b0;
   endtask

   task automatic t_reset();
      int v;
      check("R1 irq after reset", int'(irq), 0);
      check("R1 ack data after reset", int'(ack_data), 1023);
      claim(v);
      check("R1 claim after reset", v, 1023);
   endtask

   task automatic t_disable();
      int v;
      prio[40*PW +: PW] = 8'h10;
      set_ctrl(1'b0, 8'hF0);
      pulse(40, 0);
      tick(2);
      check("R2 irq low while disabled", int'(irq), 0);
      claim(v);
      check("R2 claim while disabled", v, 1023);
      set_ctrl(1'b1, 8'hF0);
      check("R10 irq not yet raised", int'(irq), 0);
      tick(1);
      check("R10 irq raised one cycle later", int'(irq), 1);
      claim(v);
      check("R6 claim returns kept pending 40", v, 40);
      tick(2);
      check("R6 irq drops after claim", int'(irq), 0);
      retire(40);
      tick(2);
      check("R8 retire does not re-pend", int'(irq), 0);
   endtask

   task automatic t_mask();
      int v;
      prio[33*PW +: PW] = 8'hF0;
      pulse(33, 0);
      tick(2);
      check("R3 equal to mask not signalled", int'(irq), 0);
      claim(v);
      check("R7 spurious when only masked", v, 1023);
      set_ctrl(1'b1, 8'hF1);
      tick(1);
      check("R3 below mask signalled", int'(irq), 1);
      claim(v);
      check("R3 claim 33 after mask raise", v, 33);
      retire(33);
      set_ctrl(1'b1, 8'hF0);
   endtask

   task automatic t_order();
      int v;
      prio[20*PW +: PW] = 8'h40;
      prio[50*PW +: PW] = 8'h20;
      prio[35*PW +: PW] = 8'h20;
      pulse(20, 0);
      pulse(50, 0);
      pulse(35, 0);
      tick(1);
      claim(v);
      check("R4 tie goes to lower ID 35", v, 35);
      claim(v);
      check("R4 next best 50", v, 50);
      claim(v);
      check("R4 lowest urgency last 20", v, 20);
      claim(v);
      check("R7 spurious when drained", v, 1023);
      retire(35); retire(50); retire(20);
      claim(v);
      check("R7 nothing re-pended", v, 1023);
   endtask

   task automatic t_sgi();
      int v;
      prio[3*PW +: PW] = 8'h00;
      pulse(3, 5);
      tick(1);
      claim(v);
      check("R5 SGI claim carries source", v, (5 << 10) | 3);
      pulse(3, 5);
      retire((2 << 10) | 3);
      claim(v);
      check("R9 wrong source keeps active", v, 1023);
      retire((5 << 10) | 3);
      claim(v);
      check("R11 re-pended SGI after retire", v, (5 << 10) | 3);
      retire((5 << 10) | 3);
   endtask

   task automatic t_repend();
      int v;
      prio[60*PW +: PW] = 8'h30;
      pulse(60, 7);
      tick(1);
      claim(v);
      check("R5 device ID has zero source", v, 60);
      pulse(60, 0);
      tick(2);
      check("R6 active not presented", int'(irq), 0);
      claim(v);
      check("R6 active not claimable", v, 1023);
      retire(60);
      check("R10 irq one cycle after retire", int'(irq), 0);
      tick(1);
      check("R11 held pulse presented", int'(irq), 1);
      claim(v);
      check("R8 re-claim 60", v, 60);
      retire(60);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_disable();
      t_mask();
      t_order();
      t_sgi();
      t_repend();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule